// File: doc/BRIEF.md
# Corner-Turning Double Buffer

This block holds two square bit arrays, each 64 words of 64 bits, built from registers. At any moment one array is the burst buffer, loaded or unloaded one word per cycle by the memory transfer side. The other is the active buffer, streamed through an external processing pipeline. The transfer side swaps the two roles with a one-cycle request. The swap is accepted only when nothing is in flight on either side.

Every access, on either side, picks row or column orientation. A row access moves the stored word as it is. A column access gathers one bit from every row. Data written as bit-planes (rows) can therefore be read back as per-cell words (columns), and the reverse also works.

The active side runs passes of 64 reads and 64 writes from latched base addresses. The write stream starts a programmable number of cycles after the read stream, which covers the pipeline latency. After that delay the write address follows the read address one step per cycle.

Top module: `corner_turn_dbuf`

## Requirements
- R1: After reset, `bank_sel` is 0, `act_busy` is 0, `act_rvalid` is 0 and `act_wstrobe` is 0.
- R2: A burst row write with `bst_col`=0 stores `bst_wdata` as word `bst_addr`. A burst read with `bst_re`=1 presents the selected word on `bst_rdata` one clock edge after the request is sampled.
- R3: A column access with index c (`bst_col`=1, or the active column selects) maps bit c of row r to bit r of the word. A column read returns that word. A column write stores data bit r into bit c of row r and leaves every other bit of each row unchanged.
- R4: When `bank_sel`=0, buffer 0 is the burst buffer and buffer 1 is the active buffer. When `bank_sel`=1, the roles are reversed. An accepted `swap_req` inverts `bank_sel` on the edge that samples it.
- R5: `swap_req` is ignored while `act_busy` is 1, or while `act_start`, `bst_re` or `bst_we` is 1 in the same cycle.
- R6: Call E0 the edge that samples `act_start` with `act_busy`=0. Active word (`act_rd_base`+k) mod 64, for k in 0..63, is read at edge E0+1+k in the orientation `act_rd_col`. It appears on `act_rdata` after that edge. `act_rvalid` is 1 after that edge only if `act_rd_en` was 1 in the cycle before it.
- R7: With delay D = `act_delay`, `act_wstrobe` is 1 in the cycle after edge E0+D+k, for k in 0..63. At edge E0+1+D+k, `act_wdata` is written to active word (`act_wr_base`+k) mod 64 in orientation `act_wr_col`. A cycle with `act_wr_en`=0 writes nothing.
- R8: A read and a write that reach the same bit at the same edge return the old contents on the read.
- R9: `act_busy` is 1 from E0 through edge E0+D+64, where it falls. An `act_start` seen while `act_busy` is 1 is ignored, along with any base or delay value presented with it.
- R10: 64 rows written through the burst side and then read as 64 columns return the transpose: bit r of column c equals bit c of row r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swap_req | input | 1 | Request to exchange buffer roles |
| bank_sel | output | 1 | Index of the buffer acting as burst buffer |
| bst_re | input | 1 | Burst-side read request |
| bst_we | input | 1 | Burst-side write request |
| bst_col | input | 1 | Burst-side access is a column (1) or a row (0) |
| bst_addr | input | 6 | Burst-side row or column index |
| bst_wdata | input | 64 | Burst-side write word |
| bst_rdata | output | 64 | Burst-side read word |
| act_start | input | 1 | Start an active pass |
| act_rd_col | input | 1 | Pass reads columns (1) or rows (0), latched at start |
| act_wr_col | input | 1 | Pass writes columns (1) or rows (0), latched at start |
| act_rd_base | input | 6 | First read index, latched at start |
| act_wr_base | input | 6 | First write index, latched at start |
| act_delay | input | 4 | Read-to-write start delay in cycles, latched at start |
| act_rd_en | input | 1 | Per-cycle read enable |
| act_wr_en | input | 1 | Per-cycle write enable |
| act_wdata | input | 64 | Active-side write word |
| act_rdata | output | 64 | Active-side read word |
| act_rvalid | output | 1 | `act_rdata` carries a fresh read |
| act_wstrobe | output | 1 | The next edge consumes `act_wdata` |
| act_busy | output | 1 | Active pass in progress |

## Verification
A wrong role flag shows up on the burst port at the next read: a pattern written before the swap shows up on the wrong side of the swap. A misplaced row/column index fold shows up on the first column read as a word that is not the transpose. A counter that is off by one moves `act_wstrobe`, or ends `act_busy`, a cycle early or late within one pass. It also lands written words on shifted indices, which shows up when those indices are read back after the next swap. A read-after-write ordering error shows up on the first read of a pass with equal bases and no delay.

// File: rtl/corner_turn_dbuf.sv
module corner_turn_dbuf #(
  parameter int W    = 64,
  parameter int DLYW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 swap_req,
  output logic                 bank_sel,
  input  logic                 bst_re,
  input  logic                 bst_we,
  input  logic                 bst_col,
  input  logic [$clog2(W)-1:0] bst_addr,
  input  logic [W-1:0]         bst_wdata,
  output logic [W-1:0]         bst_rdata,
  input  logic                 act_start,
  input  logic                 act_rd_col,
  input  logic                 act_wr_col,
  input  logic [$clog2(W)-1:0] act_rd_base,
  input  logic [$clog2(W)-1:0] act_wr_base,
  input  logic [DLYW-1:0]      act_delay,
  input  logic                 act_rd_en,
  input  logic                 act_wr_en,
  input  logic [W-1:0]         act_wdata,
  output logic [W-1:0]         act_rdata,
  output logic                 act_rvalid,
  output logic                 act_wstrobe,
  output logic                 act_busy
);
  localparam int AW = $clog2(W);
  localparam int TW = $clog2(W + (1 << DLYW)) + 1;

  logic [W-1:0]    mem [2][W];
  logic [TW-1:0]   t;
  logic            rcol, wcol;
  logic [AW-1:0]   rbase, wbase, ra, wa;
  logic [DLYW-1:0] dly;
  logic [W-1:0]    bcol, acol, bword, aword;
  logic            rd_phase, wr_phase, last, swap_ok;

  assign ra       = rbase + t[AW-1:0];
  assign wa       = wbase + AW'(t - TW'(dly));
  assign rd_phase = act_busy && (t < TW'(W));
  assign wr_phase = act_busy && (t >= TW'(dly)) && ((t - TW'(dly)) < TW'(W));
  assign last     = act_busy && (t == TW'(dly) + TW'(W - 1));
  assign swap_ok  = swap_req && !act_busy && !act_start && !bst_re && !bst_we;
  assign act_wstrobe = wr_phase;

  always_comb begin
    for (int r = 0; r < W; r++) begin
      bcol[r] = mem[bank_sel][r][bst_addr];
      acol[r] = mem[~bank_sel][r][ra];
    end
  end
  assign bword = bst_col ? bcol : mem[bank_sel][bst_addr];
  assign aword = rcol ? acol : mem[~bank_sel][ra];

  always_ff @(posedge clk) begin
    if (bst_we) begin
      if (bst_col) for (int r = 0; r < W; r++) mem[bank_sel][r][bst_addr] <= bst_wdata[r];
      else mem[bank_sel][bst_addr] <= bst_wdata;
    end
    if (wr_phase && act_wr_en) begin
      if (wcol) for (int r = 0; r < W; r++) mem[~bank_sel][r][wa] <= act_wdata[r];
      else mem[~bank_sel][wa] <= act_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_sel   <= 1'b0;
      act_busy   <= 1'b0;
      act_rvalid <= 1'b0;
      act_rdata  <= '0;
      bst_rdata  <= '0;
      t          <= '0;
      rcol       <= 1'b0;
      wcol       <= 1'b0;
      rbase      <= '0;
      wbase      <= '0;
      dly        <= '0;
    end else begin
      if (swap_ok) bank_sel <= ~bank_sel;
      if (bst_re) bst_rdata <= bword;
      act_rvalid <= rd_phase && act_rd_en;
      if (rd_phase && act_rd_en) act_rdata <= aword;
      if (!act_busy && act_start) begin
        act_busy <= 1'b1;
        t        <= '0;
        rcol     <= act_rd_col;
        wcol     <= act_wr_col;
        rbase    <= act_rd_base;
        wbase    <= act_wr_base;
        dly      <= act_delay;
      end else if (act_busy) begin
        t <= t + 1'b1;
        if (last) act_busy <= 1'b0;
      end
    end
  end

  AST_SWAP_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_sel) |-> !$past(act_busy) && !$past(bst_re) && !$past(bst_we)); // R5
  AST_SWAP_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    swap_req && !act_busy && !act_start && !bst_re && !bst_we |=> bank_sel != $past(bank_sel)); // R4
  AST_RVALID_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    act_rvalid |-> $past(act_busy)); // R6
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_busy) |-> $past(act_start)); // R9
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    act_start && !act_busy |=> act_busy); // R9
endmodule

// File: tb/corner_turn_dbuf_test.sv
`timescale 1ns/1ps
module corner_turn_dbuf_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        swap_req = 0, bank_sel;
  logic        bst_re = 0, bst_we = 0, bst_col = 0;
  logic [5:0]  bst_addr = 0;
  logic [63:0] bst_wdata = 0, bst_rdata;
  logic        act_start = 0, act_rd_col = 0, act_wr_col = 0;
  logic [5:0]  act_rd_base = 0, act_wr_base = 0;
  logic [3:0]  act_delay = 0;
  logic        act_rd_en = 0, act_wr_en = 0;
  logic [63:0] act_wdata = 0, act_rdata;
  logic        act_rvalid, act_wstrobe, act_busy;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  corner_turn_dbuf uut (.*);

  always #2 clk = ~clk;

  localparam logic [69:0] VEC [8] = '{
    {6'd0,  64'hFFFF_FFFF_FFFF_FFFF},
    {6'd63, 64'h8000_0000_0000_0001},
    {6'd1,  64'h0123_4567_89AB_CDEF},
    {6'd2,  64'h0000_0000_0000_0000},
    {6'd62, 64'hFFFF_0000_FFFF_0000},
    {6'd31, 64'hA5A5_A5A5_A5A5_A5A5},
    {6'd32, 64'h5A5A_5A5A_5A5A_5A5A},
    {6'd3,  64'hDEAD_BEEF_0BAD_F00D}
  };

  function automatic logic [63:0] pat(int r);
    logic [31:0] a, b;
    a = (32'(r) * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
    b = ~(32'(r + 7) * 32'h85EB_CA6B);
    return {a, b};
  endfunction
  function automatic logic [63:0] pat2(int r);
    return {32'(r) * 32'h2545_F491, ~(32'(r) * 32'h27D4_EB2F) ^ 32'h1357_9BDF};
  endfunction
  function automatic logic [63:0] pat3(int r);
    return {32'(r + 3) * 32'hC2B2_AE35, 32'(r) * 32'h1656_67B1 ^ 32'hF0F0_3C3C};
  endfunction
  function automatic logic [63:0] colpat(int c);
    logic [63:0] v;
    for (int r = 0; r < 64; r++) v[r] = pat(r)[c];
    return v;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bwrite(logic col, int a, logic [63:0] d);
    bst_we = 1; bst_col = col; bst_addr = 6'(a); bst_wdata = d;
    step();
    bst_we = 0;
  endtask

  task automatic bread(logic col, int a, output logic [63:0] d);
    bst_re = 1; bst_col = col; bst_addr = 6'(a);
    step();
    bst_re = 0;
    d = bst_rdata;
  endtask

  task automatic start_pass(logic rc, logic wc, int rb, int wb, int d);
    act_start = 1; act_rd_col = rc; act_wr_col = wc;
    act_rd_base = 6'(rb); act_wr_base = 6'(wb); act_delay = 4'(d);
    step();
    act_start = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [63:0] q;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 bank_sel", 64'(bank_sel), 0);
    chk("R1 act_busy", 64'(act_busy), 0);
    chk("R1 act_rvalid", 64'(act_rvalid), 0);
    chk("R1 act_wstrobe", 64'(act_wstrobe), 0);

    // R2 vector table: row writes then row reads
    foreach (VEC[i]) bwrite(0, int'(VEC[i][69:64]), VEC[i][63:0]);
    foreach (VEC[i]) begin
      bread(0, int'(VEC[i][69:64]), d);
      chk("R2 row readback", d, VEC[i][63:0]);
    end

    // R10 transpose through burst side
    for (int r = 0; r < 64; r++) bwrite(0, r, pat(r));
    for (int c = 0; c < 64; c++) begin
      bread(1, c, d);
      chk("R10 column is transpose", d, colpat(c));
    end

    // R3 column write touches only its bit
    q = 64'hC3A5_0F96_7E18_E1D2;
    bwrite(1, 7, q);
    for (int r = 0; r < 64; r++) begin
      logic [63:0] e;
      e = pat(r); e[7] = q[r];
      bread(0, r, d);
      chk("R3 column write", d, e);
    end
    bwrite(1, 7, colpat(7));

    // R5 swap ignored with a burst read in the same cycle
    swap_req = 1; bst_re = 1; bst_addr = 0;
    step();
    swap_req = 0; bst_re = 0;
    chk("R5 swap blocked by burst access", 64'(bank_sel), 0);
    // R4 swap when idle
    swap_req = 1;
    step();
    swap_req = 0;
    chk("R4 swap toggles", 64'(bank_sel), 1);
    bwrite(0, 0, 64'h1111_2222_3333_4444);
    bread(0, 0, d);
    chk("R4 burst side now buffer 1", d, 64'h1111_2222_3333_4444);

    // Pass 1: column reads, writes disabled, D=3; R6 R7 R9
    act_rd_en = 1; act_wr_en = 0;
    start_pass(1, 0, 5, 0, 3);
    for (int j = 0; j <= 3 + 66; j++) begin
      chk("R9 busy window", 64'(act_busy), 64'(j <= 3 + 63));
      chk("R7 wstrobe window", 64'(act_wstrobe), 64'(j >= 3 && j <= 3 + 63));
      chk("R6 rvalid window", 64'(act_rvalid), 64'(j >= 1 && j <= 64));
      if (j >= 1 && j <= 64)
        chk("R6 column stream", act_rdata, colpat((5 + j - 1) % 64));
      act_start = (j == 10); act_rd_base = (j == 10) ? 6'd9 : 6'd5;
      swap_req = (j == 20);
      step();
      act_start = 0; swap_req = 0;
      if (j == 20) chk("R5 swap blocked while busy", 64'(bank_sel), 1);
    end

    // Pass 2: D=0, equal bases, rows; R8 read returns old contents
    act_rd_en = 1; act_wr_en = 1;
    start_pass(0, 0, 0, 0, 0);
    for (int j = 0; j <= 65; j++) begin
      if (j >= 1 && j <= 64) chk("R8 old data on collision", act_rdata, pat(j - 1));
      act_wdata = pat2(j);
      step();
    end

    // Pass 3: column writes, D=1, odd k only, reads disabled; R3 R7
    act_rd_en = 0;
    start_pass(0, 1, 0, 60, 1);
    for (int j = 0; j <= 66; j++) begin
      chk("R6 rvalid low with read disabled", 64'(act_rvalid), 0);
      act_wdata = pat3(j - 1);
      act_wr_en = (j >= 1) && ((j - 1) % 2 == 1);
      step();
    end
    act_wr_en = 0;

    swap_req = 1;
    step();
    swap_req = 0;
    chk("R4 swap back", 64'(bank_sel), 0);
    for (int r = 0; r < 64; r++) begin
      logic [63:0] e;
      for (int c = 0; c < 64; c++) begin
        int k;
        k = (c - 60 + 64) % 64;
        e[c] = (k % 2 == 1) ? pat3(k)[r] : pat2(r)[c];
      end
      bread(0, r, d);
      chk("R7 active writes landed", d, e);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule